// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers level-sensitive interrupt requests from a parameterized set of peripheral lines and two software trap lines. It chooses one winner and raises a single request to the processor when that winner's urgency is above the masking level the core currently holds. Alongside the request it presents the address of the service routine for the winner. While the core sits in a low-power wait or stop state, a separate wake line tells the clock logic to restart.

Each peripheral line has an enable bit and a one-bit priority (high or low), written through a small write-only configuration port that also loads the vector base. Urgency runs from software traps (trap 0 ahead of trap 1), through high peripherals, to low peripherals. Within one class the lower index wins. Requests are sampled into a register stage, and the arbitration result is registered in a second stage. This gives a fixed two-edge latency, well inside the 14 to 24 cycle budget the core allows.

Top module: `intc_top`

## Requirements
- R1: While reset is held, and at the first edge after it, `core_irq_o` and `wake_o` are 0 and `vec_o` is 0. Reset clears every enable and priority bit and sets the vector base to 0.
- R2: A software trap beats every peripheral whatever its priority. When both traps request, trap 0 wins. Trap 0 is source number 0 and trap 1 is source number 1.
- R3: Any enabled high-priority peripheral (priority bit 1) beats any low-priority one (priority bit 0). Within the same class, the lower peripheral index wins. Peripheral index i is source number i+2.
- R4: The winner's level is coded 3 for a trap, 2 for a high peripheral and 1 for a low peripheral. `core_irq_o` is 1 only when this level is strictly greater than `core_lvl_i` (0 to 3). `core_lvl_i` is sampled at the output-stage edge.
- R5: When `core_irq_o` is 1, `vec_o` equals (base + 2 × source number) modulo 2^VEC_W. When `core_irq_o` is 0, `vec_o` is 0.
- R6: A peripheral whose enable bit is 0 never wins arbitration and never raises `wake_o`.
- R7: `wake_o` is 1 when `wait_i` or `stop_i` was high at the output-stage edge and some enabled peripheral or trap was pending in the sampled stage. The masking level does not affect it.
- R8: A request present at clock edge k is reflected on the outputs after edge k+1. A request that drops is likewise gone after two edges.
- R9: A write with `cfg_we` sets the enable and priority bits of peripheral `cfg_idx` at that edge. The new values qualify requests sampled from the next edge on. A write with `base_we` changes the base used by outputs computed from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | N_SRC | Level peripheral requests |
| trap_i | input | 2 | Software trap requests (bit 0 most urgent) |
| cfg_we | input | 1 | Write enable/priority of one peripheral |
| cfg_idx | input | IDX_W | Peripheral index for the write |
| cfg_en | input | 1 | Enable value to write |
| cfg_pri | input | 1 | Priority value to write (1 = high) |
| base_we | input | 1 | Load vector base |
| base_data | input | VEC_W | New vector base |
| core_lvl_i | input | 2 | Core masking level |
| wait_i | input | 1 | Core is in wait state |
| stop_i | input | 1 | Core is in stop state |
| core_irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | VEC_W | Service routine address |
| wake_o | output | 1 | Clock restart request |

## Verification
The bench builds the block with N_SRC = 8 and VEC_W = 12. With eight lines, random request patterns often hit the lowest and highest index, mixed priority classes and simultaneous traps. The narrow 12-bit vector lets a base near the top of the range wrap the address sum, so the modulo rule of R5 is checked directly. A behavioural model predicts the request, vector and wake outputs on every cycle, and directed steps pin the latency and write-timing corners.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TRAP = 2'd3
  } lvl_e;
endpackage

// File: rtl/intc_cfg.sv
module intc_cfg #(
  parameter int N_SRC = 64,
  parameter int VEC_W = 16,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_en,
  input  logic             cfg_pri,
  input  logic             base_we,
  input  logic [VEC_W-1:0] base_data,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] pri_o,
  output logic [VEC_W-1:0] base_o
);
  logic [N_SRC-1:0] en_q, pri_q;
  logic [VEC_W-1:0] base_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[g]  <= 1'b0;
        pri_q[g] <= 1'b0;
      end else if (cfg_we && (cfg_idx == IDX_W'(g))) begin
        en_q[g]  <= cfg_en;
        pri_q[g] <= cfg_pri;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          base_q <= '0;
    else if (base_we) base_q <= base_data;
  end

  assign en_o   = en_q;
  assign pri_o  = pri_q;
  assign base_o = base_q;
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int N_SRC = 64,
  localparam int SN_W = $clog2(N_SRC + 2)
) (
  input  logic [1:0]       trap,
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] pri,
  output lvl_e             lvl_o,
  output logic [SN_W-1:0]  src_o
);
  logic            hi_hit, lo_hit;
  logic [SN_W-1:0] hi_src, lo_src;

  // scan downwards so the lowest index is written last and wins
  always_comb begin
    hi_hit = 1'b0;
    lo_hit = 1'b0;
    hi_src = '0;
    lo_src = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i] && pri[i]) begin
        hi_hit = 1'b1;
        hi_src = SN_W'(i + 2);
      end
      if (pend[i] && !pri[i]) begin
        lo_hit = 1'b1;
        lo_src = SN_W'(i + 2);
      end
    end
  end

  always_comb begin
    if (trap[0]) begin
      lvl_o = LVL_TRAP; src_o = SN_W'(0);
    end else if (trap[1]) begin
      lvl_o = LVL_TRAP; src_o = SN_W'(1);
    end else if (hi_hit) begin
      lvl_o = LVL_HIGH; src_o = hi_src;
    end else if (lo_hit) begin
      lvl_o = LVL_LOW;  src_o = lo_src;
    end else begin
      lvl_o = LVL_NONE; src_o = '0;
    end
  end
endmodule

// File: rtl/intc_vec.sv
module intc_vec #(
  parameter int VEC_W = 16,
  parameter int SN_W  = 7
) (
  input  logic [VEC_W-1:0] base,
  input  logic [SN_W-1:0]  src,
  output logic [VEC_W-1:0] addr
);
  logic [VEC_W-1:0] offs;
  assign offs = VEC_W'({src, 1'b0});
  assign addr = base + offs;
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int N_SRC = 64,
  parameter int VEC_W = 16,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int SN_W  = $clog2(N_SRC + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [1:0]       trap_i,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_en,
  input  logic             cfg_pri,
  input  logic             base_we,
  input  logic [VEC_W-1:0] base_data,
  input  logic [1:0]       core_lvl_i,
  input  logic             wait_i,
  input  logic             stop_i,
  output logic             core_irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             wake_o
);
  logic [N_SRC-1:0] en, pri;
  logic [VEC_W-1:0] base;

  intc_cfg #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_pri(cfg_pri),
    .base_we(base_we), .base_data(base_data),
    .en_o(en), .pri_o(pri), .base_o(base)
  );

  // stage 1: sample qualified requests
  logic [N_SRC-1:0] s1_pend_q;
  logic [1:0]       s1_trap_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_pend_q <= '0;
      s1_trap_q <= '0;
    end else begin
      s1_pend_q <= irq_i & en;
      s1_trap_q <= trap_i;
    end
  end

  lvl_e            win_lvl;
  logic [SN_W-1:0] win_src;
  intc_arb #(.N_SRC(N_SRC)) u_arb (
    .trap(s1_trap_q), .pend(s1_pend_q), .pri(pri),
    .lvl_o(win_lvl), .src_o(win_src)
  );

  logic [VEC_W-1:0] win_addr;
  intc_vec #(.VEC_W(VEC_W), .SN_W(SN_W)) u_vec (
    .base(base), .src(win_src), .addr(win_addr)
  );

  logic pass, any_pend;
  assign pass     = (win_lvl > core_lvl_i);
  assign any_pend = (|s1_pend_q) | (|s1_trap_q);

  // stage 2: registered outputs
  logic             irq_q, wake_q;
  logic [VEC_W-1:0] vec_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= pass;
      vec_q  <= pass ? win_addr : '0;
      wake_q <= (wait_i | stop_i) & any_pend;
    end
  end

  assign core_irq_o = irq_q;
  assign vec_o      = vec_q;
  assign wake_o     = wake_q;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int N_SRC = 64,
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] irq_i,
  input logic [1:0]       trap_i,
  input logic [1:0]       core_lvl_i,
  input logic             wait_i,
  input logic             stop_i,
  input logic             core_irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             wake_o
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!core_irq_o && !wake_o && vec_o == '0));

  p_mask_all_r4: assert property (@(posedge clk) disable iff (rst)
    core_irq_o |-> ($past(core_lvl_i) != 2'd3));

  p_mask_trap_only_r4: assert property (@(posedge clk) disable iff (rst)
    (core_irq_o && $past(core_lvl_i) == 2'd2) |-> ($past(trap_i, 2) != 2'b00));

  p_cause_two_edges_r8: assert property (@(posedge clk) disable iff (rst)
    core_irq_o |-> ($past(|{trap_i, irq_i}, 2)));

  p_wake_lowpower_r7: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(wait_i || stop_i));
endmodule

bind intc_top intc_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .irq_i(irq_i), .trap_i(trap_i),
  .core_lvl_i(core_lvl_i), .wait_i(wait_i), .stop_i(stop_i),
  .core_irq_o(core_irq_o), .vec_o(vec_o), .wake_o(wake_o)
);

// File: tb/intc_top_bench.sv
`timescale 1ns/1ps
module intc_top_bench;
  localparam int N  = 8;
  localparam int VW = 12;
  localparam int IW = $clog2(N);

  logic clk = 0, rst = 1;
  always #5 clk = ~clk;

  logic [N-1:0]  irq_i = '0;
  logic [1:0]    trap_i = '0, core_lvl_i = '0;
  logic          cfg_we = 0, cfg_en = 0, cfg_pri = 0, base_we = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [VW-1:0] base_data = '0;
  logic          wait_i = 0, stop_i = 0;
  logic          core_irq_o, wake_o;
  logic [VW-1:0] vec_o;

  intc_top #(.N_SRC(N), .VEC_W(VW)) u_intc_top (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit [N-1:0] m_en, m_pri, p_irq;
  bit [1:0]   p_trap;
  int         m_base;
  bit         m_irq, m_wake;
  int         m_vec;

  always @(posedge clk) begin
    if (rst) begin
      m_en = '0; m_pri = '0; p_irq = '0; p_trap = '0; m_base = 0;
      m_irq = 0; m_wake = 0; m_vec = 0;
    end else begin
      int lvl, src;
      lvl = 0; src = 0;
      if (p_trap[0]) begin lvl = 3; src = 0; end
      else if (p_trap[1]) begin lvl = 3; src = 1; end
      else begin
        for (int i = 0; i < N; i++)
          if (p_irq[i] && m_pri[i] && lvl < 2) begin lvl = 2; src = i + 2; end
        if (lvl == 0)
          for (int i = 0; i < N; i++)
            if (p_irq[i] && lvl == 0) begin lvl = 1; src = i + 2; end
      end
      m_irq  = (lvl > int'(core_lvl_i));
      m_vec  = m_irq ? ((m_base + 2 * src) % (1 << VW)) : 0;
      m_wake = (wait_i || stop_i) && (p_irq != 0 || p_trap != 0);
      p_trap = trap_i;
      p_irq  = irq_i & m_en;
      if (cfg_we) begin m_en[cfg_idx] = cfg_en; m_pri[cfg_idx] = cfg_pri; end
      if (base_we) m_base = int'(base_data);
    end
  end

  always @(negedge clk) if (!rst && !done) begin
    check(core_irq_o == m_irq, "R4 model irq", int'(core_irq_o), int'(m_irq));
    check(int'(vec_o) == m_vec, "R5 model vec", int'(vec_o), m_vec);
    check(wake_o == m_wake, "R7 model wake", int'(wake_o), int'(m_wake));
  end

  task automatic wr(input int idx, input bit en, input bit pr);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_en = en; cfg_pri = pr;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wbase(input int b);
    base_we = 1; base_data = VW'(b);
    @(negedge clk); base_we = 0;
  endtask

  task automatic settle; repeat (3) @(negedge clk); endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!core_irq_o && !wake_o && vec_o == 0, "R1 reset outputs", int'(vec_o), 0);
    rst = 0;
    @(negedge clk);
    check(!core_irq_o && vec_o == 0, "R1 after reset", int'(vec_o), 0);
    // all sources disabled after reset: request is ignored
    irq_i = 8'hFF; wait_i = 1; settle;
    check(!core_irq_o && !wake_o, "R1 R6 disabled after reset", int'(core_irq_o), 0);
    irq_i = '0; wait_i = 0;

    wbase(12'h100);
    for (int i = 0; i < N - 1; i++) wr(i, 1, i == 5);
    settle;

    // latency R8: one edge after drive nothing, two edges after drive valid
    irq_i = 8'b0010_1000;
    @(negedge clk);
    check(!core_irq_o, "R8 not yet after one edge", int'(core_irq_o), 0);
    @(negedge clk);
    check(core_irq_o && vec_o == 12'h10E, "R8 R3 high beats lower low", int'(vec_o), 12'h10E);

    irq_i = 8'b0010_1000; irq_i[1] = 1; settle;
    check(vec_o == 12'h10E, "R3 high over low index 1", int'(vec_o), 12'h10E);
    irq_i = 8'b0000_1010; settle;
    check(vec_o == 12'h106, "R3 lower low index wins", int'(vec_o), 12'h106);
    irq_i = 8'b0010_1000;
    settle;

    core_lvl_i = 2; @(negedge clk);
    check(!core_irq_o && vec_o == 0, "R4 R5 level 2 masks high", int'(vec_o), 0);
    core_lvl_i = 1; @(negedge clk);
    check(core_irq_o && vec_o == 12'h10E, "R4 level 1 passes high", int'(vec_o), 12'h10E);

    core_lvl_i = 2; trap_i = 2'b10; settle;
    check(core_irq_o && vec_o == 12'h102, "R2 trap 1 over peripherals", int'(vec_o), 12'h102);
    trap_i = 2'b11; settle;
    check(vec_o == 12'h100, "R2 trap 0 over trap 1", int'(vec_o), 12'h100);
    core_lvl_i = 3; @(negedge clk);
    check(!core_irq_o, "R4 level 3 masks traps", int'(core_irq_o), 0);

    // drop requests: gone after two edges
    trap_i = 0; irq_i = 0; core_lvl_i = 0;
    repeat (2) @(negedge clk);
    check(!core_irq_o && vec_o == 0, "R8 drop after two edges", int'(vec_o), 0);

    // disable index 5
    wr(5, 0, 1);
    irq_i = 8'b0010_1000; settle;
    check(vec_o == 12'h10A, "R6 disabled high cannot win", int'(vec_o), 12'h10A);
    irq_i = 8'b0010_0000; stop_i = 1; settle;
    check(!wake_o && !core_irq_o, "R6 disabled gives no wake", int'(wake_o), 0);
    irq_i = 8'b0010_1000; core_lvl_i = 3; settle;
    check(wake_o && !core_irq_o, "R7 wake despite mask", int'(wake_o), 1);
    stop_i = 0; @(negedge clk);
    check(!wake_o, "R7 wake needs low power", int'(wake_o), 0);
    irq_i = 0; core_lvl_i = 0; settle;

    // R9: write and request at the same edge
    cfg_we = 1; cfg_idx = IW'(7); cfg_en = 1; cfg_pri = 1; irq_i = 8'h80;
    @(negedge clk); cfg_we = 0;
    @(negedge clk);
    check(!core_irq_o, "R9 old enable at write edge", int'(core_irq_o), 0);
    @(negedge clk);
    check(core_irq_o && vec_o == 12'h112, "R9 new enable next edge", int'(vec_o), 12'h112);

    // R5 wrap with narrow vector
    irq_i = 8'b0000_1000;
    wbase(12'hFFE); settle;
    check(vec_o == 12'h008, "R5 vector wraps", int'(vec_o), 12'h008);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      irq_i      = N'($urandom) & N'($urandom);
      trap_i     = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      core_lvl_i = 2'($urandom);
      wait_i     = ($urandom % 4 == 0);
      stop_i     = ($urandom % 6 == 0);
      cfg_we     = ($urandom % 3 == 0);
      cfg_idx    = IW'($urandom); cfg_en = 1'($urandom); cfg_pri = 1'($urandom);
      base_we    = ($urandom % 20 == 0);
      base_data  = VW'($urandom);
      @(negedge clk);
    end
    cfg_we = 0; base_we = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R8 watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule